// File: doc/BRIEF.md
# Phase Detector with Lock Indicator

This block compares a locally divided reference pulse train against a feedback pulse train that arrives from an external loop divider. It issues up and down requests for an external charge pump, and a lock flag that drops while the two trains are out of phase. The reference train comes from a programmable divider on the block clock. A monitor output shows one of the two compared trains.

A single polarity input swaps the sense of the pump requests, for loops whose oscillator tunes the other way. The same input picks which compared train appears on the monitor output. Each pump request is provided active-high, and also active-low for a pull-down (open-drain style) pump driver. The board should hold the polarity input high when nothing drives it, which gives normal sense.

Top module: `phase_lock_detector`

## Requirements
- R1: While rst_ni is low, up_o and dn_o are 0, up_no and dn_no are 1, lock_o is 1, and mon_o is 0 when pol_i is 1.
- R2: The reference pulse fr is high for exactly one cycle out of every ratio_i cycles. The first pulse is visible after the first rising clock edge following reset release, so it is seen after edges 1, 1+ratio_i, 1+2*ratio_i, and so on.
- R3: A ratio_i value below 8 divides by 8.
- R4: An fr pulse visible after edge k sets the up request after edge k+1. A rising edge of fp_i sampled at edge k sets the down request after edge k. Each request stays set until it is cleared.
- R5: When the up and down requests are both set after an edge, both are clear after the next edge.
- R6: With pol_i = 1, up_o carries the up request and dn_o carries the down request. With pol_i = 0 the two are swapped. The swap is combinational.
- R7: up_no is always the complement of up_o, and dn_no is always the complement of dn_o.
- R8: After edge k, lock_o is 0 exactly when a pump request (up or down) was present after both edge k-1 and edge k-2. A single-cycle coincidence of both requests therefore leaves lock_o at 1.
- R9: mon_o shows fr when pol_i is 1 and shows fp_i, combinationally, when pol_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the reference divider input |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 14 | Reference divide ratio, valid from 8 to 16383 |
| fp_i | input | 1 | Feedback pulse train, synchronous to clk_i |
| pol_i | input | 1 | Polarity: 1 gives normal pump sense and fr on the monitor; the board should pull it high |
| up_o | output | 1 | Pump-up request, active high |
| dn_o | output | 1 | Pump-down request, active high |
| up_no | output | 1 | Pump-up request, active low |
| dn_no | output | 1 | Pump-down request, active low |
| lock_o | output | 1 | High while the phases agree |
| mon_o | output | 1 | Monitor of fr or fp_i |

## Verification
Every result has a fixed latency, counted from the edge after which its cause becomes visible:
- fr appears one edge after the divider count reaches zero.
- The up request follows fr by one edge.
- The down request appears at the edge that samples the fp_i rise.
- Both requests clear one edge after they coincide.
- lock_o falls two edges after a request appears and rises one edge after the last request is gone.
- The polarity swap and the monitor path add no latency.

For each cycle, the driver computes the expected output vector from the scheduled fp_i pulses, the polarity and the ratio, and pushes it into a queue tagged with the edge count. The monitor compares each entry half a cycle after that edge. The fp_i pulses lead the reference by up to two cycles, coincide with it, or trail it by up to three cycles, under both polarities.

// File: rtl/pld_pkg.sv
package pld_pkg;
  localparam int unsigned RATIO_W   = 14;
  localparam int unsigned RATIO_MIN = 8;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;
endpackage

// File: rtl/pld_ref_div.sv
module pld_ref_div #(
  parameter int unsigned W   = pld_pkg::RATIO_W,
  parameter int unsigned MIN = pld_pkg::RATIO_MIN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  output logic         fr_o
);
  logic [W-1:0] eff_ratio;
  logic [W-1:0] cnt_q;
  logic         fr_q;

  // ratios below the minimum are clamped
  assign eff_ratio = (ratio_i < W'(MIN)) ? W'(MIN) : ratio_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fr_q  <= 1'b0;
    end else begin
      fr_q  <= (cnt_q == '0);
      cnt_q <= (cnt_q == '0) ? eff_ratio - W'(1) : cnt_q - W'(1);
    end
  end

  assign fr_o = fr_q;

  // R2
  fr_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_q |=> !fr_q);
endmodule

// File: rtl/pld_pfd_core.sv
module pld_pfd_core
  import pld_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fr_i,
  input  logic  fp_i,
  output pump_t pump_o,
  output logic  lock_o
);
  logic  fp_d_q;
  logic  fp_ev;
  pump_t pump_q;
  logic  err;
  logic  err_d_q;
  logic  lock_q;

  assign fp_ev = fp_i & ~fp_d_q;
  assign err   = pump_q.up | pump_q.dn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_d_q  <= 1'b0;
      pump_q  <= '0;
      err_d_q <= 1'b0;
      lock_q  <= 1'b1;
    end else begin
      fp_d_q  <= fp_i;
      err_d_q <= err;
      // single-cycle activity (aligned edges) does not drop lock
      lock_q  <= ~(err & err_d_q);
      if (pump_q.up && pump_q.dn) begin
        pump_q <= '0;
      end else begin
        pump_q.up <= pump_q.up | fr_i;
        pump_q.dn <= pump_q.dn | fp_ev;
      end
    end
  end

  assign pump_o = pump_q;
  assign lock_o = lock_q;

  // R5
  both_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pump_q.up && pump_q.dn) |=> (!pump_q.up && !pump_q.dn));
  // R4
  up_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_i && !(pump_q.up && pump_q.dn)) |=> pump_q.up);
  // R4
  dn_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_i && !fp_d_q && !(pump_q.up && pump_q.dn)) |=> pump_q.dn);
endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
  import pld_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               fp_i,
  input  logic               pol_i,
  output logic               up_o,
  output logic               dn_o,
  output logic               up_no,
  output logic               dn_no,
  output logic               lock_o,
  output logic               mon_o
);
  logic  fr;
  pump_t pump;

  pld_ref_div #(
    .W   (RATIO_W),
    .MIN (RATIO_MIN)
  ) u_ref_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio_i),
    .fr_o    (fr)
  );

  pld_pfd_core u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fr_i   (fr),
    .fp_i   (fp_i),
    .pump_o (pump),
    .lock_o (lock_o)
  );

  // polarity low reverses pump sense
  assign up_o  = pol_i ? pump.up : pump.dn;
  assign dn_o  = pol_i ? pump.dn : pump.up;
  assign up_no = ~up_o;
  assign dn_no = ~dn_o;
  assign mon_o = pol_i ? fr : fp_i;

  // R8
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((up_o || dn_o) && $past(up_o || dn_o)) |=> !lock_o);
  // R8
  lock_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_o && !dn_o) |=> lock_o);
endmodule

// File: tb/phase_lock_detector_bench.sv
`timescale 1ns/1ps
module phase_lock_detector_bench;
  localparam int NP = 6;

  typedef struct {
    int         k;
    logic [5:0] v;   // {up, dn, upn, dnn, lock, mon}
    logic       pol;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ratio = 14'd8;
  logic        fp = 1'b0;
  logic        pol = 1'b1;
  logic        up, dn, upn, dnn, lock, mon;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    n_cur = 8;
  int    ratio_cur = 8;
  bit    done = 1'b0;
  item_t q[$];
  item_t it;

  int   d_a[NP]   = '{0, 1, 3, -1, -2, 2};
  logic pol_a[NP] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  phase_lock_detector u_phase_lock_detector (
    .clk_i (clk), .rst_ni (rst_n), .ratio_i (ratio), .fp_i (fp), .pol_i (pol),
    .up_o (up), .dn_o (dn), .up_no (upn), .dn_no (dnn), .lock_o (lock), .mon_o (mon)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  function automatic logic fp_plan(int k);
    for (int m = 0; m < NP; m++) begin
      int p = 1 + n_cur * m + 1 + d_a[m];
      if (k == p - 1 || k == p) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic up_raw(int k);
    for (int m = 0; m < NP; m++) begin
      int f = 1 + n_cur * m;
      int p = f + 1 + d_a[m];
      int b = (p > f + 1) ? p : f + 1;
      if (k >= f + 1 && k <= b) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic dn_raw(int k);
    for (int m = 0; m < NP; m++) begin
      int f = 1 + n_cur * m;
      int p = f + 1 + d_a[m];
      int b = (p > f + 1) ? p : f + 1;
      if (k >= p && k <= b) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic lock_exp(int k);
    for (int m = 0; m < NP; m++) begin
      int f = 1 + n_cur * m;
      int p = f + 1 + d_a[m];
      int a = (p < f + 1) ? p : f + 1;
      int b = (p > f + 1) ? p : f + 1;
      if (k >= a + 2 && k <= b + 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic pol_plan(int k);
    int m = (k - 1) / n_cur;
    if (k < 1) return 1'b1;
    if (m >= NP) m = NP - 1;
    return pol_a[m];
  endfunction

  // driver: schedules inputs and pushes expected vectors
  task automatic run(input int r, input int n);
    ratio_cur = r;
    n_cur = n;
    rst_n = 1'b0;
    ratio = 14'(r);
    fp = 1'b0;
    pol = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(up, 1'b0, "R1", "up_o in reset");
    chk(dn, 1'b0, "R1", "dn_o in reset");
    chk(upn, 1'b1, "R1", "up_no in reset");
    chk(dnn, 1'b1, "R1", "dn_no in reset");
    chk(lock, 1'b1, "R1", "lock_o in reset");
    chk(mon, 1'b0, "R1", "mon_o in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int k = 1; k <= NP * n; k++) begin
      logic p, u, d, fr_k;
      @(posedge clk); #1;
      p    = pol_plan(k);
      u    = up_raw(k);
      d    = dn_raw(k);
      fr_k = (((k - 1) % n) == 0);
      fp   = fp_plan(k);
      pol  = p;
      it.k   = k;
      it.pol = p;
      it.v[5] = p ? u : d;
      it.v[4] = p ? d : u;
      it.v[3] = ~it.v[5];
      it.v[2] = ~it.v[4];
      it.v[1] = lock_exp(k);
      it.v[0] = p ? fr_k : fp_plan(k);
      q.push_back(it);
    end
    repeat (3) @(posedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 scoreboard: actual %0d pending expected 0", q.size());
      q.delete();
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && q.size() > 0 && q[0].k == cyc) begin
      item_t e;
      e = q.pop_front();
      chk(up,  e.v[5], e.pol ? "R4 R5" : "R6", "up_o");
      chk(dn,  e.v[4], e.pol ? "R4 R5" : "R6", "dn_o");
      chk(upn, e.v[3], "R7", "up_no");
      chk(dnn, e.v[2], "R7", "dn_no");
      chk(lock, e.v[1], "R8", "lock_o");
      chk(mon, e.v[0], e.pol ? ((ratio_cur != n_cur) ? "R3" : "R2") : "R9", "mon_o");
    end
  end

  initial begin
    run(8, 8);
    run(3, 8);      // clamped ratio
    run(11, 11);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule